// File: doc/BRIEF.md
# I2C SCL Waveform and SDA Hold Timer

This block paces an I2C master. From the peripheral clock it builds the low and the released (high) phases of SCL and the delay after each SCL fall before SDA may change. Software loads one configuration word holding a low-phase divider, a high-phase divider and a power-of-two prescaler exponent, plus a separate hold count. The byte engine of the master consumes the tick strobes: a fall tick when SCL is pulled low, a rise tick when SCL is let go, and an SDA tick when the data line may be updated.

The controller is a four-state machine. `ST_OFF` holds SCL released while the block is disabled. Transition OFF to LOW is taken when `enable` is high. `ST_LOW` drives SCL low and counts the low phase. Transition LOW to RELEASE is taken once the low count has run out and the SDA hold tick has fired. `ST_RELEASE` lets SCL go and waits until the synchronised line reads high. A target that holds SCL low keeps the machine here and stretches the clock. Transition RELEASE to HIGH is taken when the synchronised line is high. `ST_HIGH` counts the high phase. Transition HIGH to LOW is taken when that count runs out. Any state moves to OFF on the cycle after `enable` drops.

Each phase length is the divider shifted left by the prescaler exponent, plus a fixed offset. The dividers, the exponent and the hold count are sampled only on entry to `ST_LOW`.

Top module: `scl_timing_gen`

## Requirements
- R1: With no hold extension, `scl_drive_low` stays high for exactly `lo_div * 2^e + OFFSET` clock cycles. OFFSET defaults to 4, and `e` is the effective exponent.
- R2: The high count starts only after the synchronised SCL line reads high. Without stretching, SCL stays released for `hi_div * 2^e + OFFSET + SYNC_STAGES + 1` cycles from the rise tick to the next fall tick. This is `hi_div * 2^e + 7` cycles with the defaults.
- R3: In `cfg_word`, bits 18:16 are the prescaler exponent, bits 15:8 the high-phase divider and bits 7:0 the low-phase divider.
- R4: An exponent above EXP_MAX (default 6) acts as EXP_MAX.
- R5: Let cycle T be the one in which the fall tick is high. `sda_tick` is high in cycle T + h + 3, where h is the effective hold count, so a hold of 0 still gives 3 cycles.
- R6: A hold count above HOLD_MAX (default 40) acts as HOLD_MAX.
- R7: The low phase lasts `max(L_low, h + 4)` cycles. The SDA tick always falls inside the low phase, and it may fall in its last cycle.
- R8: While a target holds SCL low after release, the released phase grows by the number of cycles the line stays low.
- R9: Configuration changed during a period affects neither the current low phase nor the following high phase. It takes effect from the next fall.
- R10: After `enable` is seen low, the next cycle and all following cycles have SCL released and no ticks. After `enable` rises, the next cycle begins a low phase with a fall tick.
- R11: The fall tick is high only in the first low cycle and the rise tick only in the first released cycle. Each appears once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the clock generator when high |
| cfg_word | input | 19 | Exponent [18:16], high divider [15:8], low divider [7:0] |
| hold_cfg | input | 6 | SDA hold count before the fixed 3 cycles are added |
| scl_in | input | 1 | Sensed SCL bus line, asynchronous |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_fall_tick | output | 1 | First cycle of a low phase |
| scl_rise_tick | output | 1 | First cycle of a released phase |
| sda_tick | output | 1 | SDA may change in this cycle |

## Verification
The end of the low count and the SDA hold tick can land in the same cycle. When that happens, the machine must leave the low state right after the tick and must neither drop the tick nor add an extra low cycle. A vector with zero dividers, a zero exponent and a zero hold puts both events in cycle 3 after the fall. The bench expects a low phase of exactly 4 cycles with the SDA tick in its last cycle. Other vectors push the hold past the low count, and the low phase is then judged to stretch to h + 4 cycles.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_LOW     = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HIGH    = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);
    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= line_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[STAGES-2:0], line_in};
            end
        end
    endgenerate

    assign line_sync = sr_q[STAGES-1];
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 3,
    parameter int EXP_MAX = 6,
    parameter int OFFSET  = 4,
    parameter int LEN_W   = DIV_W + (1 << EXP_W)
) (
    input  logic [DIV_W-1:0] div,
    input  logic [EXP_W-1:0] exponent,
    output logic [LEN_W-1:0] len
);
    logic [EXP_W-1:0] exp_eff;
    logic [LEN_W-1:0] scaled;

    always_comb begin
        exp_eff = (exponent > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exponent;
        scaled  = {{(LEN_W-DIV_W){1'b0}}, div} << exp_eff;
        len     = scaled + LEN_W'(OFFSET);
    end
endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer #(
    parameter int HOLD_W   = 6,
    parameter int HOLD_MAX = 40,
    parameter int HOLD_FIX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cancel,
    input  logic [HOLD_W-1:0] hold_val,
    output logic              busy,
    output logic              tick
);
    localparam int HCNT_W = HOLD_W + 2;

    logic [HOLD_W-1:0] hold_eff;
    logic [HCNT_W-1:0] hcnt_q;
    logic              busy_q;

    always_comb begin
        hold_eff = (hold_val > HOLD_W'(HOLD_MAX)) ? HOLD_W'(HOLD_MAX) : hold_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            busy_q <= 1'b0;
        end else if (cancel) begin
            hcnt_q <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            hcnt_q <= HCNT_W'(hold_eff) + HCNT_W'(HOLD_FIX);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (hcnt_q == '0) busy_q <= 1'b0;
            else              hcnt_q <= hcnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign tick = busy_q && (hcnt_q == '0);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int EXP_W       = 3,
    parameter int EXP_MAX     = 6,
    parameter int HOLD_W      = 6,
    parameter int HOLD_MAX    = 40,
    parameter int HOLD_FIX    = 3,
    parameter int OFFSET      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W      = 2 * DIV_W + EXP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [HOLD_W-1:0] hold_cfg,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              scl_fall_tick,
    output logic              scl_rise_tick,
    output logic              sda_tick
);
    localparam int LEN_W   = DIV_W + (1 << EXP_W);
    localparam int LO_LSB  = 0;
    localparam int HI_LSB  = DIV_W;
    localparam int EXP_LSB = 2 * DIV_W;

    scl_state_e state_q, state_nx;
    logic       first_q;
    logic [LEN_W-1:0] cnt_q;
    logic [DIV_W-1:0] hi_div_q;
    logic [EXP_W-1:0] exp_q;

    logic [LEN_W-1:0] lo_len, hi_len;
    logic             scl_sync;
    logic             hold_busy, hold_tick;
    logic             enter_low, enter_high;

    // Live word feeds the low-phase length; the high phase uses the latched copy
    scl_phase_len #(.DIV_W(DIV_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX),
                    .OFFSET(OFFSET), .LEN_W(LEN_W)) u_lo_len (
        .div      (cfg_word[LO_LSB +: DIV_W]),
        .exponent (cfg_word[EXP_LSB +: EXP_W]),
        .len      (lo_len)
    );

    scl_phase_len #(.DIV_W(DIV_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX),
                    .OFFSET(OFFSET), .LEN_W(LEN_W)) u_hi_len (
        .div      (hi_div_q),
        .exponent (exp_q),
        .len      (hi_len)
    );

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .line_sync (scl_sync)
    );

    sda_hold_timer #(.HOLD_W(HOLD_W), .HOLD_MAX(HOLD_MAX),
                     .HOLD_FIX(HOLD_FIX)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (enter_low),
        .cancel   (!enable),
        .hold_val (hold_cfg),
        .busy     (hold_busy),
        .tick     (hold_tick)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:     if (enable) state_nx = ST_LOW;
            ST_LOW:     if ((cnt_q == '0) && (!hold_busy || hold_tick))
                            state_nx = ST_RELEASE;
            ST_RELEASE: if (scl_sync) state_nx = ST_HIGH;
            ST_HIGH:    if (cnt_q == '0) state_nx = ST_LOW;
            default:    state_nx = ST_OFF;
        endcase
        if (!enable) state_nx = ST_OFF;
        enter_low  = (state_nx == ST_LOW)  && (state_q != ST_LOW);
        enter_high = (state_nx == ST_HIGH) && (state_q != ST_HIGH);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            first_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            first_q <= (state_nx != state_q);
        end
    end

    // Phase counter and configuration latched at each low-phase start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            hi_div_q <= '0;
            exp_q    <= '0;
        end else if (enter_low) begin
            cnt_q    <= lo_len - 1'b1;
            hi_div_q <= cfg_word[HI_LSB +: DIV_W];
            exp_q    <= cfg_word[EXP_LSB +: EXP_W];
        end else if (enter_high) begin
            cnt_q    <= hi_len - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        scl_drive_low = (state_q == ST_LOW);
        scl_fall_tick = (state_q == ST_LOW) && first_q;
        scl_rise_tick = (state_q == ST_RELEASE) && first_q;
        sda_tick      = hold_tick;
    end
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_drive_low,
    input logic scl_fall_tick,
    input logic scl_rise_tick,
    input logic sda_tick
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               pend_q <= 1'b0;
        else if (scl_fall_tick)                   pend_q <= 1'b1;
        else if (sda_tick || !scl_drive_low)      pend_q <= 1'b0;
    end

    // R11
    fall_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_tick |-> scl_drive_low);

    // R11
    rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_tick |-> (!scl_drive_low && $past(scl_drive_low)));

    // R5
    sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_tick |-> scl_drive_low);

    // R7
    hold_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise_tick |-> !pend_q);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !scl_fall_tick && !scl_rise_tick && !sda_tick));
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .scl_drive_low (scl_drive_low),
    .scl_fall_tick (scl_fall_tick),
    .scl_rise_tick (scl_rise_tick),
    .sda_tick      (sda_tick)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [18:0] cfg_word = '0;
    logic [5:0]  hold_cfg = '0;
    logic        stretch = 1'b0;
    logic        scl_line;
    logic        scl_drive_low, scl_fall_tick, scl_rise_tick, sda_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_line = ~scl_drive_low & ~stretch;

    scl_timing_gen #(.EXP_MAX(6), .HOLD_MAX(40), .OFFSET(4)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .cfg_word      (cfg_word),
        .hold_cfg      (hold_cfg),
        .scl_in        (scl_line),
        .scl_drive_low (scl_drive_low),
        .scl_fall_tick (scl_fall_tick),
        .scl_rise_tick (scl_rise_tick),
        .sda_tick      (sda_tick)
    );

    // lo, hi, exp, hold, expected low cycles, expected sda offset, expected released cycles
    localparam int NV = 7;
    localparam int VEC [NV][7] = '{
        '{  3, 5, 0,  0,   7,  3, 12},
        '{  2, 1, 2,  5,  12,  8, 11},
        '{  0, 0, 0,  0,   4,  3,  7},
        '{  1, 2, 1, 10,  14, 13, 11},
        '{  1, 1, 7,  0,  68,  3, 71},
        '{  2, 0, 0, 63,  44, 43,  7},
        '{255, 3, 0,  2, 259,  5, 10}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic logic [18:0] mk_cfg(input int lo, input int hi, input int e);
        return {3'(e), 8'(hi), 8'(lo)};
    endfunction

    // Measures one period starting at the next fall tick; must be called at a negedge
    task automatic measure(input int stretch_n, input int chg_k,
                           input logic [18:0] chg_w, input logic [5:0] chg_h,
                           output int low_n, output int sda_k, output int rel_n,
                           output int falls, output int rise_ok);
        int k;
        while (!scl_fall_tick) @(negedge clk);
        k = 0; low_n = 0; sda_k = -1; falls = 0; rel_n = 0;
        while (scl_drive_low) begin
            if (sda_tick) sda_k = k;
            if (scl_fall_tick) falls++;
            if (k == chg_k) begin
                cfg_word = chg_w;
                hold_cfg = chg_h;
            end
            low_n++; k++;
            @(negedge clk);
        end
        rise_ok = scl_rise_tick ? 1 : 0;
        while (!scl_fall_tick) begin
            stretch = (rel_n < stretch_n);
            if (sda_tick) sda_k = 1000;
            rel_n++;
            @(negedge clk);
        end
        stretch = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int lo_n, sda_k, rel_n, falls, rise_ok;
        repeat (3) @(negedge clk);
        check(!scl_drive_low && !scl_fall_tick && !scl_rise_tick && !sda_tick,
              "R10 reset outputs idle", int'(scl_drive_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_drive_low && !sda_tick, "R10 disabled after reset", int'(scl_drive_low), 0);

        cfg_word = mk_cfg(VEC[0][0], VEC[0][1], VEC[0][2]);
        hold_cfg = 6'(VEC[0][3]);
        enable = 1'b1;
        @(negedge clk);
        check(scl_fall_tick && scl_drive_low, "R10 enable starts low phase",
              int'(scl_fall_tick), 1);

        // Vector walk: R1 R2 R3 R4 R5 R6 R7 R11
        for (int v = 0; v < NV; v++) begin
            cfg_word = mk_cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
            hold_cfg = 6'(VEC[v][3]);
            measure(0, -1, '0, '0, lo_n, sda_k, rel_n, falls, rise_ok);
            measure(0, -1, '0, '0, lo_n, sda_k, rel_n, falls, rise_ok);
            check(lo_n == VEC[v][4], $sformatf("R1 R3 R4 R7 low length vec%0d", v), lo_n, VEC[v][4]);
            check(sda_k == VEC[v][5], $sformatf("R5 R6 sda offset vec%0d", v), sda_k, VEC[v][5]);
            check(rel_n == VEC[v][6], $sformatf("R2 R3 R4 released length vec%0d", v), rel_n, VEC[v][6]);
            check(falls == 1 && rise_ok == 1, $sformatf("R11 tick placement vec%0d", v), falls, 1);
        end

        // R9: change mid low phase, current period keeps old setting
        cfg_word = mk_cfg(3, 5, 0);
        hold_cfg = 6'd0;
        measure(0, -1, '0, '0, lo_n, sda_k, rel_n, falls, rise_ok);
        measure(0, 2, mk_cfg(2, 2, 0), 6'd1, lo_n, sda_k, rel_n, falls, rise_ok);
        check(lo_n == 7, "R9 current low unchanged", lo_n, 7);
        check(rel_n == 12, "R9 current high unchanged", rel_n, 12);
        measure(0, -1, '0, '0, lo_n, sda_k, rel_n, falls, rise_ok);
        check(lo_n == 6, "R9 next low uses new setting", lo_n, 6);
        check(sda_k == 4, "R9 next hold uses new setting", sda_k, 4);
        check(rel_n == 9, "R9 next high uses new setting", rel_n, 9);

        // R8: target stretches SCL low for 10 cycles
        cfg_word = mk_cfg(3, 5, 0);
        hold_cfg = 6'd0;
        measure(0, -1, '0, '0, lo_n, sda_k, rel_n, falls, rise_ok);
        measure(10, -1, '0, '0, lo_n, sda_k, rel_n, falls, rise_ok);
        check(rel_n == 22, "R8 stretched released phase", rel_n, 22);
        check(lo_n == 7, "R8 low phase unaffected", lo_n, 7);

        // R10: disable in the middle of a low phase
        while (!scl_fall_tick) @(negedge clk);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R10 release on disable", int'(scl_drive_low), 0);
        begin
            int act = 0;
            for (int i = 0; i < 40; i++) begin
                if (scl_drive_low || scl_fall_tick || scl_rise_tick || sda_tick) act++;
                @(negedge clk);
            end
            check(act == 0, "R10 no activity while disabled", act, 0);
        end
        enable = 1'b1;
        @(negedge clk);
        check(scl_fall_tick && scl_drive_low, "R10 re-enable fall tick", int'(scl_fall_tick), 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule